// File: doc/BRIEF.md
# Iterative Shift-Subtract Unsigned Divider

This block divides an unsigned dividend of `DW` bits by an unsigned divisor of half that width. It takes one quotient bit per clock cycle. A one-cycle start pulse captures both operands. The divisor is held in a register, and the dividend enters a left-shifting register. The partial remainder is one half-word wide. On each cycle, the partial remainder with the next dividend bit appended forms a minuend one bit wider than the half word. A subtractor of that width takes the divisor away from it.

The carry out of that subtraction is the quotient bit for the cycle. It is written into a quotient array register at the bit position given by a down-counter, which holds the number of iterations left. When the carry is clear, the difference would be negative, so the minuend is kept as the new partial remainder. The remainder therefore never goes below zero.

When the counter runs out, the core raises a one-cycle done pulse. The quotient and remainder then stay on the outputs until the next accepted start. A zero divisor finishes straight away and raises a divide-by-zero flag.

Top module: `shiftsub_divider`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: For a nonzero divisor, `quotient` in the done cycle equals floor(dividend / divisor), computed over the full `DW` bits.
- R3: For a nonzero divisor, `remainder` in the done cycle equals dividend mod divisor. It is zero-extended to `DW` bits and is always below the divisor.
- R4: For a nonzero divisor, `done` is high for exactly one cycle. It rises after the `DW+1`-th rising edge, counting the edge that samples `start` as the first, because one quotient bit is resolved per cycle after that edge.
- R5: For a zero divisor, the done pulse follows the edge that samples `start`. In that cycle `div_by_zero` is 1, `quotient` is all ones and `remainder` equals the dividend.
- R6: Between a done pulse and the next accepted start, `quotient` and `remainder` do not change, even when the operand inputs change.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The running division finishes on its original operands and at its original time.
- R8: `busy` is high from the cycle after an accepted nonzero-divisor start up to, but not including, the done cycle, and low in the done cycle.
- R9: An accepted start with a nonzero divisor clears `div_by_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request, accepted only while idle |
| dividend | input | DW | Unsigned dividend, sampled with start |
| divisor | input | DW/2 | Unsigned divisor, sampled with start |
| busy | output | 1 | An iteration is in progress |
| done | output | 1 | One-cycle completion pulse |
| div_by_zero | output | 1 | The last accepted divisor was zero |
| quotient | output | DW | Quotient array register |
| remainder | output | DW | Final remainder, or the dividend for a zero divisor |

## Verification
The assertions assume that `start` is low while reset is high, and that operands are only meaningful in the cycle where `start` is accepted. The hold check further assumes that nothing other than an accepted start clears the quotient array.

The bench drives every input on the falling edge and raises `start` for a single cycle. The only exception is a deliberate extra pulse sent in the middle of a run to show that it is ignored. All operands in the bench are legal unsigned values, and the divisor values include zero, one and the largest half-word value.

// File: rtl/shiftsub_div_pkg.sv
package shiftsub_div_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Result of one trial subtraction step.
    typedef struct packed {
        logic carry;
        logic last;
    } step_flags_t;

    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ssd_subtractor.sv
module ssd_subtractor #(
    parameter int HW = 8
) (
    input  logic [HW:0]   minuend,
    input  logic [HW-1:0] subtrahend,
    output logic          carry,
    output logic [HW-1:0] next_rem
);
    localparam int SW = HW + 2;

    logic [SW-1:0] diff;

    always_comb begin
        diff     = {1'b0, minuend} - {2'b00, subtrahend};
        carry    = ~diff[SW-1];
        next_rem = carry ? diff[HW-1:0] : minuend[HW-1:0];
    end

    // When the step fails, the minuend must already be below the divisor.
    always_comb begin
        if (!carry) begin
            assert_keep_fits_R3: assert (minuend[HW] == 1'b0);
        end
    end
endmodule

// File: rtl/ssd_qarray.sv
module ssd_qarray #(
    parameter int W  = 16,
    parameter int PW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          fill,
    input  logic          we,
    input  logic [PW-1:0] pos,
    input  logic          bit_in,
    output logic [W-1:0]  q
);
    for (genvar i = 0; i < W; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                q[i] <= 1'b0;
            end else if (fill) begin
                q[i] <= 1'b1;
            end else if (we && (pos == PW'(i))) begin
                q[i] <= bit_in;
            end
        end
    end

    assert_pos_range_R2: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(pos) < W));
endmodule

// File: rtl/ssd_downcount.sv
module ssd_downcount #(
    parameter int START = 16,
    parameter int CW    = $clog2(START + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= CW'(START);
        end else if (dec) begin
            count <= count - 1'b1;
        end
    end

    assign last = (count == CW'(1));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        dec |-> (count != '0));
endmodule

// File: rtl/shiftsub_divider.sv
module shiftsub_divider
    import shiftsub_div_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DW-1:0]     dividend,
    input  logic [DW/2-1:0]   divisor,
    output logic              busy,
    output logic              done,
    output logic              div_by_zero,
    output logic [DW-1:0]     quotient,
    output logic [DW-1:0]     remainder
);
    localparam int HW = DW / 2;
    localparam int CW = cnt_bits(DW);
    localparam int PW = $clog2(DW);

    run_state_e    state;
    logic [HW-1:0] div_r;
    logic [HW-1:0] rem_r;
    logic [DW-1:0] dvd_sh;
    logic [CW-1:0] count;
    logic [HW-1:0] next_rem;
    logic          accept;
    logic          zero_div;
    logic          run;
    step_flags_t   flags;

    assign accept   = start && (state == ST_IDLE);
    assign zero_div = (divisor == '0);
    assign run      = (state == ST_RUN);
    assign busy     = run;

    ssd_subtractor #(.HW(HW)) u_sub (
        .minuend    ({rem_r, dvd_sh[DW-1]}),
        .subtrahend (div_r),
        .carry      (flags.carry),
        .next_rem   (next_rem)
    );

    ssd_downcount #(.START(DW), .CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (accept && !zero_div),
        .dec   (run),
        .count (count),
        .last  (flags.last)
    );

    ssd_qarray #(.W(DW), .PW(PW)) u_qa (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept && !zero_div),
        .fill   (accept && zero_div),
        .we     (run),
        .pos    (PW'(count - 1'b1)),
        .bit_in (flags.carry),
        .q      (quotient)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            div_r       <= '0;
            rem_r       <= '0;
            dvd_sh      <= '0;
            done        <= 1'b0;
            div_by_zero <= 1'b0;
            remainder   <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                div_r       <= divisor;
                dvd_sh      <= dividend;
                rem_r       <= '0;
                div_by_zero <= zero_div;
                if (zero_div) begin
                    remainder <= dividend;
                    done      <= 1'b1;
                end else begin
                    state <= ST_RUN;
                end
            end else if (run) begin
                rem_r  <= next_rem;
                dvd_sh <= {dvd_sh[DW-2:0], 1'b0};
                if (flags.last) begin
                    state     <= ST_IDLE;
                    done      <= 1'b1;
                    remainder <= DW'(next_rem);
                end
            end
        end
    end

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_low_at_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_dbz_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (done && div_by_zero) |-> (quotient == '1));

    assert_rem_below_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (remainder < DW'(div_r)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(start)) |-> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/shiftsub_divider_tb.sv
module shiftsub_divider_tb_top;
    localparam int DW = 16;
    localparam int HW = DW / 2;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    // {dividend, divisor, quotient, remainder}
    localparam logic [DW+HW+DW+DW-1:0] VEC [NV] = '{
        {16'd1000,  8'd7,   16'd142,   16'd6},
        {16'd65535, 8'd255, 16'd257,   16'd0},
        {16'd65535, 8'd1,   16'd65535, 16'd0},
        {16'd12345, 8'd100, 16'd123,   16'd45},
        {16'd5,     8'd9,   16'd0,     16'd5},
        {16'd40000, 8'd200, 16'd200,   16'd0},
        {16'd65534, 8'd255, 16'd256,   16'd254},
        {16'd0,     8'd3,   16'd0,     16'd0},
        {16'd255,   8'd16,  16'd15,    16'd15}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [DW-1:0] dividend = '0;
    logic [HW-1:0] divisor = '0;
    logic busy, done, div_by_zero;
    logic [DW-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shiftsub_divider #(.DW(DW)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .div_by_zero(div_by_zero),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one division; returns the number of falling edges until done.
    task automatic run_div(input logic [DW-1:0] a, input logic [HW-1:0] b,
                           input logic inject, output int lat);
        int n;
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        if (b != 0) check(busy == 1'b1, "R8 busy after start", longint'(busy), 1);
        while (!done && n < 200) begin
            if (inject && n == 3) begin
                dividend = 16'd9; divisor = 8'd3; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            n++;
            if (!done && b != 0 && n < DW) check(busy == 1'b1, "R8 busy while running", longint'(busy), 1);
        end
        lat = n;
        check(busy == 1'b0, "R8 busy low at done", longint'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R4 done single cycle", longint'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && div_by_zero == 0, "R1 flags after reset",
              longint'({busy, done, div_by_zero}), 0);
        check(quotient == 0 && remainder == 0, "R1 data after reset",
              longint'(quotient) + longint'(remainder), 0);

        for (int i = 0; i < NV; i++) begin
            logic [DW-1:0] a, eq, er;
            logic [HW-1:0] b;
            {a, b, eq, er} = VEC[i];
            run_div(a, b, 1'b0, lat);
            // run_div has moved one cycle past done; outputs must still hold (R6)
            check(quotient == eq, "R2 quotient", longint'(quotient), longint'(eq));
            check(remainder == er, "R3 remainder", longint'(remainder), longint'(er));
            check(lat == DW + 1, "R4 latency", longint'(lat), DW + 1);
            check(quotient == a / DW'(b), "R2 bench model", longint'(quotient), longint'(a / DW'(b)));
        end

        // R5 divide by zero
        run_div(16'd4660, 8'd0, 1'b0, lat);
        check(lat == 1, "R5 zero-divisor latency", longint'(lat), 1);
        check(div_by_zero == 1'b1, "R5 flag", longint'(div_by_zero), 1);
        check(quotient == 16'hFFFF, "R5 quotient all ones", longint'(quotient), 65535);
        check(remainder == 16'd4660, "R5 remainder is dividend", longint'(remainder), 4660);

        // R9 flag cleared, R7 start while busy ignored
        run_div(16'd1000, 8'd7, 1'b1, lat);
        check(div_by_zero == 1'b0, "R9 flag cleared", longint'(div_by_zero), 0);
        check(quotient == 16'd142, "R7 quotient unaffected", longint'(quotient), 142);
        check(remainder == 16'd6, "R7 remainder unaffected", longint'(remainder), 6);
        check(lat == DW + 1, "R7 latency unaffected", longint'(lat), DW + 1);

        // R6 hold with changing inputs
        dividend = 16'd77; divisor = 8'd5;
        repeat (5) @(negedge clk);
        check(quotient == 16'd142, "R6 quotient held", longint'(quotient), 142);
        check(remainder == 16'd6, "R6 remainder held", longint'(remainder), 6);
        check(busy == 1'b0 && done == 1'b0, "R6 idle", longint'({busy, done}), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule